// File: doc/BRIEF.md
# Direct-Map Window Address Translator

This block is the front end of address translation. It looks at a virtual address and decides whether the address can be translated at once or must go to the TLB or page walker. It does not hold TLB contents and it does not walk page tables.

Two control bits select the translation mode: direct addressing and paging. When direct addressing is on and paging is off, every address goes straight through, masked to the physical width. In any other setting, four window registers are searched in order. Each window holds a segment tag and per-privilege enables. A matching window remaps the address with full permissions. The remapping differs in 32-bit and 64-bit mode.

If no window matches, the upper address bits must form a proper sign extension of the virtual space. An address that passes this check is handed on for mapped lookup. An address that fails it is reported as a bad address. The decision is registered, so every request gets exactly one result one clock later.

Top module: `dmw_xlate_front`

## Requirements
- R1: When `da_en`=1 and `pg_en`=0, the outcome is direct (code 1), `res_addr` = `req_va` with all bits at and above `PA_W` (48) cleared, and `res_perm` = 3'b111 (bit2 read, bit1 write, bit0 execute). This holds whatever the windows and upper address bits are.
- R2: A window may match a kernel access (`priv_user`=0) only if its bit 0 is set. It may match a user access (`priv_user`=1) only if its bit 3 is set.
- R3: In 64-bit mode (`mode64`=1) a window's segment tag is bits [63:60] of the window, compared with `req_va`[63:60]. In 32-bit mode the tag is window bits [31:29], zero-extended and compared with `req_va`[63:29]. As a result, any set address bit above bit 31 prevents a match in 32-bit mode.
- R4: When several windows match, the lowest-numbered window supplies the result.
- R5: On a 64-bit window match the outcome is direct with perm 3'b111. `res_addr` = `req_va` with bits 63:48 cleared.
- R6: On a 32-bit window match the outcome is direct with perm 3'b111. `res_addr` = {32'b0, window bits [27:25], `req_va`[28:0]}.
- R7: A window match yields a direct outcome even when `req_va`[63:48] is not a valid sign extension.
- R8: With no direct mode and no match, if `req_va`[63:48] is neither all zeros nor all ones, the outcome is bad address (code 2) with `res_addr`=0 and `res_perm`=0.
- R9: With no direct mode, no match and canonical upper bits, the outcome is needs-mapping (code 3), `res_addr` = `req_va` and `res_perm`=0.
- R10: `res_valid` is `req_valid` delayed by one clock. Results update only for accepted requests. After reset, `res_valid`=0, `res_kind`=0, `res_addr`=0 and `res_perm`=0.
- R11: With `da_en` and `pg_en` both 1, direct mode is off and the window and canonical rules apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_va | input | 64 | Virtual address |
| da_en | input | 1 | Direct addressing enable |
| pg_en | input | 1 | Paging enable |
| priv_user | input | 1 | 1 = user access, 0 = kernel access |
| mode64 | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| win_cfg | input | 4x64 | Window registers, index 0 first |
| res_valid | output | 1 | Result strobe |
| res_kind | output | 2 | 0 none, 1 direct, 2 bad address, 3 needs mapping |
| res_addr | output | 64 | Physical address or forwarded virtual address |
| res_perm | output | 3 | Read/write/execute grant |

## Verification
A window match and a canonical-address failure can both be true for the same address. The window rule must win. The bench provokes this with 64-bit addresses whose top nibble matches a window tag while bits 63:48 are not a sign extension. It expects a direct result with the masked address. It then repeats the same address at a privilege the window does not enable, and expects a bad-address result. Direct mode is also paired with matching windows and non-canonical addresses, to show that the bypass takes precedence over both.

// File: rtl/dmw_pkg.sv
// Shared types for the direct-map window translator.
package dmw_pkg;
    typedef enum logic [1:0] {
        OUT_NONE   = 2'd0,
        OUT_DIRECT = 2'd1,
        OUT_BAD    = 2'd2,
        OUT_MAP    = 2'd3
    } outcome_e;
    localparam logic [2:0] PERM_RWX = 3'b111;
endpackage

// File: rtl/dmw_win_match.sv
// One window comparator. It qualifies the window by privilege, compares the
// segment tag in the active address mode, and forms the remapped address.
// Assumes the 32-bit tag sits just below bit 32 of the window register.
module dmw_win_match #(
    parameter int VA_W      = 64,
    parameter int VIRT_BITS = 48,
    parameter int SEG_SH32  = 29,
    parameter int SEG_SH64  = 60,
    parameter int USER_BIT  = 3,
    parameter int PSEG_LSB  = 25
) (
    input  logic [VA_W-1:0] va,
    input  logic [VA_W-1:0] win,
    input  logic            mode64,
    input  logic            priv_user,
    output logic            hit,
    output logic [VA_W-1:0] paddr
);
    localparam int SEG32_W = 32 - SEG_SH32;
    localparam int SEG64_W = VA_W - SEG_SH64;
    localparam int HI32_W  = VA_W - SEG_SH32;
    localparam logic [VA_W-1:0] VMASK = {{(VA_W-VIRT_BITS){1'b0}}, {VIRT_BITS{1'b1}}};

    logic               priv_ok;
    logic [HI32_W-1:0]  va_hi32, tag32;
    logic [SEG64_W-1:0] va_hi64, tag64;
    logic [SEG32_W-1:0] pseg;

    // Tag compare and address remap for this window.
    always_comb begin
        priv_ok = priv_user ? win[USER_BIT] : win[0];
        va_hi32 = va[VA_W-1:SEG_SH32];
        tag32   = HI32_W'(win[31:SEG_SH32]);
        va_hi64 = va[VA_W-1:SEG_SH64];
        tag64   = win[VA_W-1:SEG_SH64];
        pseg    = win[PSEG_LSB +: SEG32_W];
        hit     = priv_ok && (mode64 ? (va_hi64 == tag64) : (va_hi32 == tag32));
        paddr   = mode64 ? (va & VMASK) : VA_W'({pseg, va[SEG_SH32-1:0]});
    end
endmodule

// File: rtl/dmw_first_hit.sv
// Priority picker: the lowest-indexed asserted hit supplies the address.
module dmw_first_hit #(
    parameter int N = 4,
    parameter int W = 64
) (
    input  logic [N-1:0]        hits,
    input  logic [N-1:0][W-1:0] addrs,
    output logic                any,
    output logic [W-1:0]        addr
);
    // Scan from the top down so the lowest index is assigned last.
    always_comb begin
        any  = |hits;
        addr = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) addr = addrs[i];
        end
    end
endmodule

// File: rtl/dmw_canon_chk.sv
// Canonical check: the extension field above the virtual space must be
// all zeros or all ones.
module dmw_canon_chk #(
    parameter int VA_W      = 64,
    parameter int VIRT_BITS = 48
) (
    input  logic [VA_W-1:0] va,
    output logic            ok
);
    localparam int EXT_W = VA_W - VIRT_BITS;
    logic [EXT_W-1:0] ext;

    // Compare the extension bits against both legal patterns.
    always_comb begin
        ext = va[VA_W-1:VIRT_BITS];
        ok  = (ext == '0) || (ext == '1);
    end
endmodule

// File: rtl/dmw_xlate_front.sv
// Translation front end. Fixed priority order: direct-address bypass,
// then windows 0..N-1, then the canonical check, then mapped lookup.
// Registers one result per accepted request.
module dmw_xlate_front
    import dmw_pkg::*;
#(
    parameter int VA_W      = 64,
    parameter int PA_W      = 48,
    parameter int VIRT_BITS = 48,
    parameter int NUM_WIN   = 4,
    parameter int SEG_SH32  = 29,
    parameter int SEG_SH64  = 60,
    parameter int USER_BIT  = 3,
    parameter int PSEG_LSB  = 25
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic [VA_W-1:0]               req_va,
    input  logic                          da_en,
    input  logic                          pg_en,
    input  logic                          priv_user,
    input  logic                          mode64,
    input  logic [NUM_WIN-1:0][VA_W-1:0]  win_cfg,
    output logic                          res_valid,
    output logic [1:0]                    res_kind,
    output logic [VA_W-1:0]               res_addr,
    output logic [2:0]                    res_perm
);
    localparam logic [VA_W-1:0] PMASK = {{(VA_W-PA_W){1'b0}}, {PA_W{1'b1}}};

    logic [NUM_WIN-1:0]           hits;
    logic [NUM_WIN-1:0][VA_W-1:0] win_paddr;
    logic                         any_hit;
    logic [VA_W-1:0]              hit_addr;
    logic                         canon_ok;
    outcome_e                     nxt_kind;
    logic [VA_W-1:0]              nxt_addr;
    logic [2:0]                   nxt_perm;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        dmw_win_match #(
            .VA_W(VA_W), .VIRT_BITS(VIRT_BITS), .SEG_SH32(SEG_SH32),
            .SEG_SH64(SEG_SH64), .USER_BIT(USER_BIT), .PSEG_LSB(PSEG_LSB)
        ) u_match (
            .va(req_va), .win(win_cfg[g]), .mode64(mode64),
            .priv_user(priv_user), .hit(hits[g]), .paddr(win_paddr[g])
        );
    end

    dmw_first_hit #(.N(NUM_WIN), .W(VA_W)) u_pick (
        .hits(hits), .addrs(win_paddr), .any(any_hit), .addr(hit_addr)
    );

    dmw_canon_chk #(.VA_W(VA_W), .VIRT_BITS(VIRT_BITS)) u_canon (
        .va(req_va), .ok(canon_ok)
    );

    // Apply the fixed priority order to form the next result.
    always_comb begin
        if (da_en && !pg_en) begin
            nxt_kind = OUT_DIRECT; nxt_addr = req_va & PMASK; nxt_perm = PERM_RWX;
        end else if (any_hit) begin
            nxt_kind = OUT_DIRECT; nxt_addr = hit_addr;       nxt_perm = PERM_RWX;
        end else if (!canon_ok) begin
            nxt_kind = OUT_BAD;    nxt_addr = '0;             nxt_perm = 3'b000;
        end else begin
            nxt_kind = OUT_MAP;    nxt_addr = req_va;         nxt_perm = 3'b000;
        end
    end

    // Result register: strobe follows the request, data loads on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_kind  <= OUT_NONE;
            res_addr  <= '0;
            res_perm  <= '0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) begin
                res_kind <= nxt_kind;
                res_addr <= nxt_addr;
                res_perm <= nxt_perm;
            end
        end
    end
endmodule

// File: rtl/dmw_xlate_front_chk.sv
// Port-level checker for the translator, bound to every instance.
module dmw_xlate_front_chk #(
    parameter int VA_W      = 64,
    parameter int PA_W      = 48,
    parameter int VIRT_BITS = 48
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [VA_W-1:0] req_va,
    input logic            da_en,
    input logic            pg_en,
    input logic            res_valid,
    input logic [1:0]      res_kind,
    input logic [VA_W-1:0] res_addr,
    input logic [2:0]      res_perm
);
    localparam logic [VA_W-1:0] PMASK = {{(VA_W-PA_W){1'b0}}, {PA_W{1'b1}}};
    logic [VA_W-VIRT_BITS-1:0] ext;
    logic canon;
    // Independent view of the extension field.
    always_comb begin
        ext   = req_va[VA_W-1:VIRT_BITS];
        canon = (ext == '0) || (ext == '1);
    end

    a_r10_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);
    a_r10_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);
    a_r10_kind_set: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> res_kind != 2'd0);
    a_r1_direct_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && da_en && !pg_en) |=>
        (res_kind == 2'd1 && res_perm == 3'b111 && res_addr == ($past(req_va) & PMASK)));
    a_r8_bad_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind == 2'd2) |-> (res_perm == 3'b000 && res_addr == '0));
    a_r8_canon_never_bad: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && canon) |=> res_kind != 2'd2);
    a_r9_map_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind == 2'd3) |-> (res_perm == 3'b000 && res_addr == $past(req_va)));
endmodule

bind dmw_xlate_front dmw_xlate_front_chk #(
    .VA_W(VA_W), .PA_W(PA_W), .VIRT_BITS(VIRT_BITS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .da_en(da_en), .pg_en(pg_en), .res_valid(res_valid), .res_kind(res_kind),
    .res_addr(res_addr), .res_perm(res_perm)
);

// File: tb/dmw_xlate_front_test.sv
`timescale 1ns/1ps
module dmw_xlate_front_test;
    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [63:0]      req_va = '0;
    logic             da_en = 1'b0, pg_en = 1'b1, priv_user = 1'b0, mode64 = 1'b1;
    logic [3:0][63:0] win_cfg = '0;
    logic             res_valid;
    logic [1:0]       res_kind;
    logic [63:0]      res_addr;
    logic [2:0]       res_perm;
    int               n_chk = 0, n_bad = 0;
    bit               done = 1'b0;

    always #2 clk = ~clk;

    dmw_xlate_front uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .da_en(da_en), .pg_en(pg_en), .priv_user(priv_user), .mode64(mode64),
        .win_cfg(win_cfg), .res_valid(res_valid), .res_kind(res_kind),
        .res_addr(res_addr), .res_perm(res_perm)
    );

    function automatic logic [63:0] w64(input logic [3:0] tag, input bit k, input bit u);
        return {tag, 60'b0} | (64'(u) << 3) | 64'(k);
    endfunction
    function automatic logic [63:0] w32(input logic [2:0] tag, input logic [2:0] ps,
                                        input bit k, input bit u);
        return (64'(tag) << 29) | (64'(ps) << 25) | (64'(u) << 3) | 64'(k);
    endfunction

    task automatic chk(input string tag, input logic [1:0] ek,
                       input logic [63:0] ea, input logic [2:0] ep);
        n_chk++;
        if (res_valid !== 1'b1 || res_kind !== ek || res_addr !== ea || res_perm !== ep) begin
            n_bad++;
            $display("FAIL %s: got v=%0b kind=%0d addr=%h perm=%b, want v=1 kind=%0d addr=%h perm=%b",
                     tag, res_valid, res_kind, res_addr, res_perm, ek, ea, ep);
        end
    endtask

    // Drive one request at a falling edge, check at the next falling edge.
    task automatic req(input string tag, input logic [63:0] va, input logic [1:0] ek,
                       input logic [63:0] ea, input logic [2:0] ep);
        req_va = va; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(tag, ek, ea, ep);
    endtask

    task automatic t_reset();
        n_chk++;
        if (res_valid !== 1'b0 || res_kind !== 2'd0 || res_addr !== '0 || res_perm !== '0) begin
            n_bad++;
            $display("FAIL R10 reset: got v=%0b kind=%0d addr=%h perm=%b, want all zero",
                     res_valid, res_kind, res_addr, res_perm);
        end
    endtask

    task automatic t_direct();
        win_cfg = '0; win_cfg[0] = w64(4'hF, 1, 1);
        da_en = 1; pg_en = 0; mode64 = 1; priv_user = 0;
        req("R1 bypass beats window", 64'hFFFF_1234_5678_9ABC, 2'd1, 64'h0000_1234_5678_9ABC, 3'b111);
        req("R1 bypass noncanonical", 64'h0F00_0000_0000_0042, 2'd1, 64'h42, 3'b111);
        da_en = 1; pg_en = 1; win_cfg = '0;
        req("R11 da and pg both set", 64'h0000_0000_0000_1000, 2'd3, 64'h1000, 3'b000);
        da_en = 0; pg_en = 1;
    endtask

    task automatic t_priv_vs_canon();
        win_cfg = '0; win_cfg[0] = w64(4'h9, 1, 0); mode64 = 1;
        priv_user = 0;
        req("R7 kernel hit beats canon", 64'h9000_0000_0000_1000, 2'd1, 64'h1000, 3'b111);
        priv_user = 1;
        req("R2 user blocked then R8 bad", 64'h9000_0000_0000_1000, 2'd2, 64'h0, 3'b000);
        win_cfg[0] = w64(4'h9, 0, 1);
        req("R2 user-enabled window", 64'h9000_0000_0000_2000, 2'd1, 64'h2000, 3'b111);
        priv_user = 0;
        req("R2 kernel blocked", 64'h9000_0000_0000_2000, 2'd2, 64'h0, 3'b000);
    endtask

    task automatic t_map64();
        win_cfg = '0; win_cfg[3] = w64(4'h8, 1, 0); mode64 = 1; priv_user = 0;
        req("R5 64-bit remap", 64'h8000_ABCD_1234_5678, 2'd1, 64'h0000_ABCD_1234_5678, 3'b111);
        req("R3 tag mismatch canon", 64'hFFFF_8000_0000_0010, 2'd3, 64'hFFFF_8000_0000_0010, 3'b000);
    endtask

    task automatic t_map32();
        win_cfg = '0; win_cfg[1] = w32(3'd5, 3'd3, 1, 0); mode64 = 0; priv_user = 0;
        req("R6 32-bit remap", 64'hA123_4567, 2'd1, 64'h6123_4567, 3'b111);
        req("R3 upper bits block 32-bit", 64'h1_A123_4567, 2'd3, 64'h1_A123_4567, 3'b000);
        mode64 = 1;
    endtask

    task automatic t_prio();
        win_cfg = '0; mode64 = 0; priv_user = 0;
        win_cfg[0] = w32(3'd5, 3'd1, 0, 1);
        win_cfg[1] = w32(3'd5, 3'd2, 1, 0);
        win_cfg[2] = w32(3'd5, 3'd6, 1, 0);
        req("R4 lowest enabled index", 64'hA000_0010, 2'd1, 64'h4000_0010, 3'b111);
        win_cfg[0] = w32(3'd5, 3'd1, 1, 0);
        req("R4 window 0 wins", 64'hA000_0010, 2'd1, 64'h2000_0010, 3'b111);
        mode64 = 1;
    endtask

    task automatic t_canon();
        win_cfg = '0; mode64 = 1;
        req("R9 negative canonical", 64'hFFFF_8000_0000_0000, 2'd3, 64'hFFFF_8000_0000_0000, 3'b000);
        req("R8 bad upper bits", 64'h0001_0000_0000_0000, 2'd2, 64'h0, 3'b000);
        @(negedge clk);
        n_chk++;
        if (res_valid !== 1'b0 || res_kind !== 2'd2) begin
            n_bad++;
            $display("FAIL R10 idle hold: got v=%0b kind=%0d, want v=0 kind=2", res_valid, res_kind);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_direct();
        t_priv_vs_canon();
        t_map64();
        t_map32();
        t_prio();
        t_canon();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hung run, want completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule